// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches an eight-pin input port and raises a request when a pin changes in a direction that software has asked about. Each pin has a rising detector and a falling detector, each with its own enable bit. A hit on either one sets that pin's flag. The flag stays set until software clears it.

The pins are already synchronized when they reach the block. They are captured only when the instruction-rate `sample` strobe is high. An edge is any difference between the capture just taken and the one before it.

The OR of all flags appears as a summary output. A master enable gates that summary onto the processor interrupt and onto a wake request. With the master enable off, detection and flagging continue and only the outputs stay low.

Software reaches the block through a small port with an address, a write enable and write data, plus a combinational read path. The address map is fixed:

| Address | Contents |
|---|---|
| 0 | Rising enables |
| 1 | Falling enables |
| 2 | Flags |
| 3 | Master enable, bit 0 |

Top module: `pin_edge_irq`

## Requirements
- R1: Reset clears both enable registers, the flags and the master enable. During reset the previous-level register loads the current pins, so pins that are high through reset give no flag on the first strobe after reset.
- R2: With bit i of the rising-enable register (address 0) set, a strobe that captures pin i high after a previous capture of low sets flag i on that clock edge.
- R3: With bit i of the falling-enable register (address 1) set, a strobe that captures pin i low after a previous capture of high sets flag i on that clock edge.
- R4: A pin with both enable bits set flags on an edge in either direction.
- R5: A pin whose enable bit for the edge direction seen is clear does not get a flag for that edge.
- R6: Flags are sticky. A write to address 2 leaves flag i as it was where data bit i is 1 and clears it where data bit i is 0.
- R7: An edge detected on pin i in the same cycle as a flag write leaves flag i set, whatever value is written.
- R8: `any_flag` is high exactly when at least one flag is set.
- R9: `irq` and `wake` equal `any_flag` ANDed with the master enable (address 3, bit 0). They are low while the master enable is clear, and flags are still set in that state.
- R10: Pin levels are captured only in cycles with `sample` high. A pulse that begins and ends between two strobes produces no flag.
- R11: `rdata` shows the register selected by `addr`, with the value it holds before any update in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | 8 | Synchronized pin levels |
| sample | input | 1 | Capture strobe, once per instruction cycle |
| addr | input | 2 | Register select: 0 rise, 1 fall, 2 flags, 3 master |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at `addr` |
| any_flag | output | 1 | OR of all flags |
| irq | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Wake request while asleep |

## Verification
A vector table sets the previous and new pin levels and the enable masks independently. It covers the following patterns:
- rising edges only
- falling edges only
- both directions with both enables
- opposing halves, with the port toggling under split enables
- all enables off with the whole port rising
- a sparse mix in which only disabled transitions fail to flag

Together these separate a swapped or missing direction term, and a mask taken from the wrong register. Directed cases cover the narrower points:
- pins held high through reset
- a pulse between strobes
- a clear racing an edge
- AND-mask clears
- a read taken in the cycle of an update
- the interrupt with the master enable on and off

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic            sample,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic            any_flag,
  output logic            irq,
  output logic            wake
);

  localparam logic [1:0] A_RISE = 2'd0;
  localparam logic [1:0] A_FALL = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_MSTR = 2'd3;

  logic [NPIN-1:0] rise_en, fall_en, flags, prev, hit, flags_nxt;
  logic            master;
  logic            flag_wr;

  assign hit = sample ? ((pins & ~prev & rise_en) | (~pins & prev & fall_en)) : '0;
  assign flag_wr = wr_en && (addr == A_FLAG);
  assign flags_nxt = (flag_wr ? (flags & wdata) : flags) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      flags   <= '0;
      master  <= 1'b0;
      prev    <= pins;
    end else begin
      if (sample) prev <= pins;
      if (wr_en && addr == A_RISE) rise_en <= wdata;
      if (wr_en && addr == A_FALL) fall_en <= wdata;
      if (wr_en && addr == A_MSTR) master  <= wdata[0];
      flags <= flags_nxt;
    end
  end

  always_comb begin
    case (addr)
      A_RISE:  rdata = rise_en;
      A_FALL:  rdata = fall_en;
      A_FLAG:  rdata = flags;
      default: rdata = {{(NPIN-1){1'b0}}, master};
    endcase
  end

  assign any_flag = |flags;
  assign irq      = any_flag & master;
  assign wake     = any_flag & master;

  // R6: flags that are not written keep their set bits
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (flags & $past(flags)) == $past(flags));

  // R7: a detected edge survives a same-cycle clearing write
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && hit != '0) |=> (flags & $past(hit)) == $past(hit));

  // R5: newly set flags only on pins with some enable
  a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags)) & ~($past(rise_en) | $past(fall_en))) == '0);

  // R10: nothing new is flagged without a strobe
  a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> (flags & ~$past(flags)) == '0);

  // R8: a hit raises the summary on the next cycle
  a_r8_summary: assert property (@(posedge clk) disable iff (!rst_n)
    hit != '0 |=> any_flag);

  // R9: with the master enable clear there is no request
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0 && addr == A_MSTR) |-> !irq && !wake);

endmodule

// File: tb/pin_edge_irq_bench.sv
module pin_edge_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pins;
  logic       sample;
  logic [1:0] addr;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       any_flag, irq, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pin_edge_irq u_pin_edge_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .sample(sample), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .any_flag(any_flag),
    .irq(irq), .wake(wake)
  );

  // rise_en, fall_en, prev pins, new pins, expected flags
  localparam logic [39:0] VEC [6] = '{
    {8'hFF, 8'h00, 8'h00, 8'hA5, 8'hA5},
    {8'h00, 8'hFF, 8'hFF, 8'h3C, 8'hC3},
    {8'hFF, 8'hFF, 8'h0F, 8'hF0, 8'hFF},
    {8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h5A},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00},
    {8'h81, 8'h18, 8'h99, 8'h66, 8'h18}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] p);
    @(negedge clk);
    pins = p; sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; pins = 8'hFF; sample = 1'b0; addr = 2'd0; wr_en = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset regs", v, 8'h00);
    end
    check("R1 any_flag after reset", {7'b0, any_flag}, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    strobe(8'hFF);
    rd(2'd2, v);
    check("R1 no false edge after reset", v, 8'h00);

    // R2 R3 R4 R5 table
    foreach (VEC[i]) begin
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      strobe(VEC[i][23:16]);
      wr(2'd2, 8'h00);
      wr(2'd0, VEC[i][39:32]); wr(2'd1, VEC[i][31:24]);
      strobe(VEC[i][15:8]);
      rd(2'd2, v);
      check("R2/R3/R4/R5 vector flags", v, VEC[i][7:0]);
      check("R8 summary vector", {7'b0, any_flag}, {7'b0, VEC[i][7:0] != 8'h00});
      check("R9 irq low with master off", {6'b0, irq, wake}, 8'h00);
    end

    // R10 pulse between strobes
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    strobe(8'h00);
    wr(2'd2, 8'h00);
    @(negedge clk); pins = 8'hFF;
    @(negedge clk); pins = 8'h00;
    strobe(8'h00);
    rd(2'd2, v);
    check("R10 unstrobed pulse ignored", v, 8'h00);

    // R6 sticky and mask clear
    strobe(8'hFF);
    wr(2'd2, 8'hFF);
    rd(2'd2, v);
    check("R6 write ones keeps flags", v, 8'hFF);
    wr(2'd2, 8'h0F);
    rd(2'd2, v);
    check("R6 mask clear", v, 8'h0F);

    // R9 master enable
    wr(2'd3, 8'h01);
    #1 check("R9 irq/wake with master", {6'b0, irq, wake}, 8'h03);
    wr(2'd2, 8'h00);
    #1 check("R9 irq falls after clear", {6'b0, irq, wake, any_flag}, 8'h00);
    wr(2'd3, 8'h00);

    // R7 edge beats clear; R11 read before update
    wr(2'd0, 8'h01); wr(2'd1, 8'h00);
    strobe(8'h00);
    @(negedge clk);
    addr = 2'd2; wdata = 8'h00; wr_en = 1'b1; pins = 8'h01; sample = 1'b1;
    #1 check("R11 read returns old flags", rdata, 8'h00);
    @(negedge clk);
    wr_en = 1'b0; sample = 1'b0;
    #1 check("R7 edge wins over clear", rdata, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule